// File: doc/BRIEF.md
# Split Cache Cross-Snoop Sequencer

This block keeps a split instruction cache and data cache coherent with each other, so that code which writes into its own instruction stream still fetches the new bytes. Each cache hands the block its misses. Before any external memory traffic starts, the block looks up the same line in the opposite cache. It then runs a fixed order of write-back, invalidation and fill or data access toward a simple bus that uses request/acknowledge handshakes.

Only one miss is in service at a time. The block accepts a miss with a one-cycle grant pulse. While a sequence runs it holds `busy` high, and the other requester keeps its request asserted until it is granted. Both tag arrays answer lookups in the same cycle, with a hit flag and, for the data cache, the line state. The block marks the end of each sequence with a one-cycle done pulse.

States: IDLE, DSNOOP (look up the data cache for an instruction miss), DWB (write back a modified data line), DINV (invalidate the data line), IFILL (burst read for the instruction cache), ISNOOP (look up the instruction cache for a data miss), IINV (invalidate the instruction line) and DACC (the data cache's own memory access). Transitions:
- IDLE→DSNOOP on an instruction grant, and IDLE→ISNOOP on a data grant.
- From DSNOOP: →DWB on a modified hit, →DINV on any other hit, →IFILL on a miss.
- DWB→DINV on write-back acknowledge, then DINV→IFILL.
- IFILL→IDLE on fill acknowledge.
- From ISNOOP: →IINV on a hit, →DACC on a miss. IINV→DACC.
- DACC→IDLE on access acknowledge.

Top module: `xsnoop_ctrl`

## Requirements
- R1: After an instruction-cache miss is granted, the block looks up the data cache (`dc_lkup_vld` for exactly one cycle) at the same line address (address bits 31:5) before it raises any bus request.
- R2: If that lookup reports a hit with state 2'b11 (modified), the block raises `wb_req` for that line first and holds it until `wb_ack`. No invalidate or fill occurs before then.
- R3: A data-cache lookup hit invalidates the line for one cycle (`dc_inv_vld`), whatever the state (2'b01 shared, 2'b10 exclusive or 2'b11 modified). For a modified line this follows the write-back.
- R4: When the data-cache snoop is finished, the block raises `fill_req` for the same line and holds it until `fill_ack`.
- R5: After a data-cache miss (read or write) is granted, the block looks up the instruction cache for one cycle. On a hit it pulses `ic_inv_vld` for one cycle on that line.
- R6: When the instruction-cache snoop is finished, the block raises `dacc_req` with the captured line and write flag (`dacc_we` = 1 for a write) and holds it until `dacc_ack`.
- R7: A lookup that reports no hit produces no write-back and no invalidate, even if the state lines show modified. The fill or data access follows in the next cycle.
- R8: Only one miss is serviced at a time. `busy` is high from the cycle after a grant until the sequence ends, and no grant is given while busy. If both caches request in the same idle cycle, the instruction cache is granted first.
- R9: `ic_done` (or `dc_done`) is high for exactly one cycle, in the cycle where `fill_ack` (or `dacc_ack`) is accepted.
- R10: While reset is asserted, all request, lookup, invalidate, grant, done and busy outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ic_miss_req | input | 1 | Instruction-cache read miss request, held until granted |
| ic_miss_line | input | 27 | Line address (bits 31:5) of the instruction miss |
| ic_miss_gnt | output | 1 | Instruction miss accepted this cycle |
| dc_miss_req | input | 1 | Data-cache miss request, held until granted |
| dc_miss_line | input | 27 | Line address of the data miss |
| dc_miss_we | input | 1 | Data miss is a write (1) or a read (0) |
| dc_miss_gnt | output | 1 | Data miss accepted this cycle |
| busy | output | 1 | A miss sequence is in progress |
| dc_lkup_vld | output | 1 | Data-cache tag lookup strobe |
| dc_lkup_line | output | 27 | Data-cache lookup line address |
| dc_lkup_hit | input | 1 | Data-cache lookup hit (same cycle) |
| dc_lkup_state | input | 2 | Data-cache line state: 01 shared, 10 exclusive, 11 modified |
| dc_inv_vld | output | 1 | Data-cache line invalidate strobe |
| dc_inv_line | output | 27 | Data-cache invalidate line address |
| ic_lkup_vld | output | 1 | Instruction-cache tag lookup strobe |
| ic_lkup_line | output | 27 | Instruction-cache lookup line address |
| ic_lkup_hit | input | 1 | Instruction-cache lookup hit (same cycle) |
| ic_inv_vld | output | 1 | Instruction-cache line invalidate strobe |
| ic_inv_line | output | 27 | Instruction-cache invalidate line address |
| wb_req | output | 1 | Write-back request to the bus |
| wb_line | output | 27 | Write-back line address |
| wb_ack | input | 1 | Write-back complete |
| fill_req | output | 1 | Instruction-cache burst read request |
| fill_line | output | 27 | Burst read line address |
| fill_ack | input | 1 | Burst read complete |
| dacc_req | output | 1 | Data-cache memory access request |
| dacc_line | output | 27 | Data access line address |
| dacc_we | output | 1 | Data access is a write |
| dacc_ack | input | 1 | Data access complete |
| ic_done | output | 1 | Instruction miss sequence finished (one cycle) |
| dc_done | output | 1 | Data miss sequence finished (one cycle) |

## Verification
The bench records the order of lookup, write-back, invalidate and request events in each sequence, and checks every event's line address against the captured miss. Three faults would change that recorded order:
- A design that invalidates before the write-back would lose the modified data.
- A design that trusts the state lines on a lookup miss would issue a spurious write-back.
- A design that skips the snoop would fill stale code.

The bench drives both requests in the same cycle to check instruction-first priority and that no grant leaks during a busy sequence. It also varies the acknowledge latency to catch done pulses that come early, stretch, or come with a write-back acknowledge.

// File: rtl/xsnoop_pkg.sv
`timescale 1ns/1ps
package xsnoop_pkg;

    typedef enum logic [1:0] {
        LS_INV = 2'b00,
        LS_SHR = 2'b01,
        LS_EXC = 2'b10,
        LS_MOD = 2'b11
    } line_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DSNOOP,
        ST_DWB,
        ST_DINV,
        ST_IFILL,
        ST_ISNOOP,
        ST_IINV,
        ST_DACC
    } seq_state_e;

endpackage

// File: rtl/xsnoop_arb.sv
`timescale 1ns/1ps
module xsnoop_arb #(
    parameter bit IC_FIRST = 1'b1
) (
    input  logic idle,
    input  logic ic_req,
    input  logic dc_req,
    output logic take_ic,
    output logic take_dc
);

    generate
        if (IC_FIRST) begin : g_ic_first
            always_comb begin
                take_ic = idle && ic_req;
                take_dc = idle && dc_req && !ic_req;
            end
        end else begin : g_dc_first
            always_comb begin
                take_dc = idle && dc_req;
                take_ic = idle && ic_req && !dc_req;
            end
        end
    endgenerate

endmodule

// File: rtl/xsnoop_cap.sv
`timescale 1ns/1ps
module xsnoop_cap #(
    parameter int LINE_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take_ic,
    input  logic              take_dc,
    input  logic [LINE_W-1:0] ic_line,
    input  logic [LINE_W-1:0] dc_line,
    input  logic              dc_we,
    output logic [LINE_W-1:0] cur_line,
    output logic              cur_we
);

    // Line and access type are latched at grant and stay stable for the
    // whole sequence, so every downstream port sees one address.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_line <= '0;
            cur_we   <= 1'b0;
        end else if (take_ic) begin
            cur_line <= ic_line;
            cur_we   <= 1'b0;
        end else if (take_dc) begin
            cur_line <= dc_line;
            cur_we   <= dc_we;
        end
    end

endmodule

// File: rtl/xsnoop_fsm.sv
`timescale 1ns/1ps
module xsnoop_fsm
    import xsnoop_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       take_ic,
    input  logic       take_dc,
    input  logic       dc_lkup_hit,
    input  logic [1:0] dc_lkup_state,
    input  logic       ic_lkup_hit,
    input  logic       wb_ack,
    input  logic       fill_ack,
    input  logic       dacc_ack,
    output logic       idle,
    output logic       busy,
    output logic       dc_lkup_vld,
    output logic       dc_inv_vld,
    output logic       ic_lkup_vld,
    output logic       ic_inv_vld,
    output logic       wb_req,
    output logic       fill_req,
    output logic       dacc_req,
    output logic       ic_done,
    output logic       dc_done
);

    seq_state_e state, state_nx;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Next-state selection
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (take_ic)      state_nx = ST_DSNOOP;
                else if (take_dc) state_nx = ST_ISNOOP;
            end
            ST_DSNOOP: begin
                if (dc_lkup_hit && (dc_lkup_state == LS_MOD)) state_nx = ST_DWB;
                else if (dc_lkup_hit)                         state_nx = ST_DINV;
                else                                          state_nx = ST_IFILL;
            end
            ST_DWB:    if (wb_ack)   state_nx = ST_DINV;
            ST_DINV:                 state_nx = ST_IFILL;
            ST_IFILL:  if (fill_ack) state_nx = ST_IDLE;
            ST_ISNOOP: begin
                if (ic_lkup_hit) state_nx = ST_IINV;
                else             state_nx = ST_DACC;
            end
            ST_IINV:                 state_nx = ST_DACC;
            ST_DACC:   if (dacc_ack) state_nx = ST_IDLE;
            default:                 state_nx = ST_IDLE;
        endcase
    end

    // Output decode
    always_comb begin
        dc_lkup_vld = 1'b0;
        dc_inv_vld  = 1'b0;
        ic_lkup_vld = 1'b0;
        ic_inv_vld  = 1'b0;
        wb_req      = 1'b0;
        fill_req    = 1'b0;
        dacc_req    = 1'b0;
        ic_done     = 1'b0;
        dc_done     = 1'b0;
        idle        = 1'b0;
        unique case (state)
            ST_IDLE:   idle        = 1'b1;
            ST_DSNOOP: dc_lkup_vld = 1'b1;
            ST_DWB:    wb_req      = 1'b1;
            ST_DINV:   dc_inv_vld  = 1'b1;
            ST_IFILL: begin
                fill_req = 1'b1;
                ic_done  = fill_ack;
            end
            ST_ISNOOP: ic_lkup_vld = 1'b1;
            ST_IINV:   ic_inv_vld  = 1'b1;
            ST_DACC: begin
                dacc_req = 1'b1;
                dc_done  = dacc_ack;
            end
            default:   idle        = 1'b0;
        endcase
        busy = !idle;
    end

    AST_WB_ONLY_MODIFIED: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wb_req) |-> $past(dc_lkup_vld && dc_lkup_hit && (dc_lkup_state == LS_MOD))); // R2
    AST_INV_AFTER_WB: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wb_req) |-> dc_inv_vld); // R3
    AST_FILL_AFTER_DSNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(fill_req) |-> $past(dc_lkup_vld || dc_inv_vld)); // R4
    AST_IINV_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        ic_inv_vld |-> $past(ic_lkup_vld && ic_lkup_hit)); // R5
    AST_DACC_AFTER_ISNOOP: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(dacc_req) |-> $past(ic_lkup_vld || ic_inv_vld)); // R6
    AST_DMISS_STRAIGHT_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        (dc_lkup_vld && !dc_lkup_hit) |=> (fill_req && !wb_req && !dc_inv_vld)); // R7
    AST_IMISS_STRAIGHT_ACC: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_lkup_vld && !ic_lkup_hit) |=> (dacc_req && !ic_inv_vld)); // R7
    AST_BUSY_AFTER_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        (take_ic || take_dc) |=> busy); // R8
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ic_done || dc_done) |=> !(ic_done || dc_done)); // R9

endmodule

// File: rtl/xsnoop_ctrl.sv
`timescale 1ns/1ps
module xsnoop_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter bit IC_FIRST   = 1'b1,
    localparam int OFF_W     = $clog2(LINE_BYTES),
    localparam int LINE_W    = ADDR_W - OFF_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ic_miss_req,
    input  logic [LINE_W-1:0] ic_miss_line,
    output logic              ic_miss_gnt,
    input  logic              dc_miss_req,
    input  logic [LINE_W-1:0] dc_miss_line,
    input  logic              dc_miss_we,
    output logic              dc_miss_gnt,
    output logic              busy,
    output logic              dc_lkup_vld,
    output logic [LINE_W-1:0] dc_lkup_line,
    input  logic              dc_lkup_hit,
    input  logic [1:0]        dc_lkup_state,
    output logic              dc_inv_vld,
    output logic [LINE_W-1:0] dc_inv_line,
    output logic              ic_lkup_vld,
    output logic [LINE_W-1:0] ic_lkup_line,
    input  logic              ic_lkup_hit,
    output logic              ic_inv_vld,
    output logic [LINE_W-1:0] ic_inv_line,
    output logic              wb_req,
    output logic [LINE_W-1:0] wb_line,
    input  logic              wb_ack,
    output logic              fill_req,
    output logic [LINE_W-1:0] fill_line,
    input  logic              fill_ack,
    output logic              dacc_req,
    output logic [LINE_W-1:0] dacc_line,
    output logic              dacc_we,
    input  logic              dacc_ack,
    output logic              ic_done,
    output logic              dc_done
);

    logic              idle;
    logic              take_ic;
    logic              take_dc;
    logic [LINE_W-1:0] cur_line;
    logic              cur_we;

    xsnoop_arb #(.IC_FIRST(IC_FIRST)) u_arb (
        .idle    (idle),
        .ic_req  (ic_miss_req),
        .dc_req  (dc_miss_req),
        .take_ic (take_ic),
        .take_dc (take_dc)
    );

    xsnoop_cap #(.LINE_W(LINE_W)) u_cap (
        .clk      (clk),
        .rst_n    (rst_n),
        .take_ic  (take_ic),
        .take_dc  (take_dc),
        .ic_line  (ic_miss_line),
        .dc_line  (dc_miss_line),
        .dc_we    (dc_miss_we),
        .cur_line (cur_line),
        .cur_we   (cur_we)
    );

    xsnoop_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .take_ic       (take_ic),
        .take_dc       (take_dc),
        .dc_lkup_hit   (dc_lkup_hit),
        .dc_lkup_state (dc_lkup_state),
        .ic_lkup_hit   (ic_lkup_hit),
        .wb_ack        (wb_ack),
        .fill_ack      (fill_ack),
        .dacc_ack      (dacc_ack),
        .idle          (idle),
        .busy          (busy),
        .dc_lkup_vld   (dc_lkup_vld),
        .dc_inv_vld    (dc_inv_vld),
        .ic_lkup_vld   (ic_lkup_vld),
        .ic_inv_vld    (ic_inv_vld),
        .wb_req        (wb_req),
        .fill_req      (fill_req),
        .dacc_req      (dacc_req),
        .ic_done       (ic_done),
        .dc_done       (dc_done)
    );

    always_comb begin
        ic_miss_gnt  = take_ic;
        dc_miss_gnt  = take_dc;
        dc_lkup_line = cur_line;
        dc_inv_line  = cur_line;
        ic_lkup_line = cur_line;
        ic_inv_line  = cur_line;
        wb_line      = cur_line;
        fill_line    = cur_line;
        dacc_line    = cur_line;
        dacc_we      = cur_we && dacc_req;
    end

    AST_NO_GRANT_WHILE_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !(ic_miss_gnt || dc_miss_gnt)); // R8
    AST_LINE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cur_line)); // R1

endmodule

// File: tb/tb_xsnoop_ctrl.sv
`timescale 1ns/1ps
module tb_xsnoop_ctrl;

    localparam int LINE_W = 27;
    localparam int EV_LKD  = 1;
    localparam int EV_WB   = 2;
    localparam int EV_INVD = 3;
    localparam int EV_FILL = 4;
    localparam int EV_LKI  = 5;
    localparam int EV_INVI = 6;
    localparam int EV_DACC = 7;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic              ic_miss_req = 1'b0;
    logic [LINE_W-1:0] ic_miss_line = '0;
    logic              ic_miss_gnt;
    logic              dc_miss_req = 1'b0;
    logic [LINE_W-1:0] dc_miss_line = '0;
    logic              dc_miss_we = 1'b0;
    logic              dc_miss_gnt;
    logic              busy;
    logic              dc_lkup_vld;
    logic [LINE_W-1:0] dc_lkup_line;
    logic              dc_lkup_hit = 1'b0;
    logic [1:0]        dc_lkup_state = 2'b00;
    logic              dc_inv_vld;
    logic [LINE_W-1:0] dc_inv_line;
    logic              ic_lkup_vld;
    logic [LINE_W-1:0] ic_lkup_line;
    logic              ic_lkup_hit = 1'b0;
    logic              ic_inv_vld;
    logic [LINE_W-1:0] ic_inv_line;
    logic              wb_req;
    logic [LINE_W-1:0] wb_line;
    logic              wb_ack = 1'b0;
    logic              fill_req;
    logic [LINE_W-1:0] fill_line;
    logic              fill_ack = 1'b0;
    logic              dacc_req;
    logic [LINE_W-1:0] dacc_line;
    logic              dacc_we;
    logic              dacc_ack = 1'b0;
    logic              ic_done;
    logic              dc_done;

    xsnoop_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .ic_miss_req(ic_miss_req), .ic_miss_line(ic_miss_line), .ic_miss_gnt(ic_miss_gnt),
        .dc_miss_req(dc_miss_req), .dc_miss_line(dc_miss_line), .dc_miss_we(dc_miss_we),
        .dc_miss_gnt(dc_miss_gnt), .busy(busy),
        .dc_lkup_vld(dc_lkup_vld), .dc_lkup_line(dc_lkup_line), .dc_lkup_hit(dc_lkup_hit),
        .dc_lkup_state(dc_lkup_state), .dc_inv_vld(dc_inv_vld), .dc_inv_line(dc_inv_line),
        .ic_lkup_vld(ic_lkup_vld), .ic_lkup_line(ic_lkup_line), .ic_lkup_hit(ic_lkup_hit),
        .ic_inv_vld(ic_inv_vld), .ic_inv_line(ic_inv_line),
        .wb_req(wb_req), .wb_line(wb_line), .wb_ack(wb_ack),
        .fill_req(fill_req), .fill_line(fill_line), .fill_ack(fill_ack),
        .dacc_req(dacc_req), .dacc_line(dacc_line), .dacc_we(dacc_we), .dacc_ack(dacc_ack),
        .ic_done(ic_done), .dc_done(dc_done)
    );

    int checks = 0;
    int fails = 0;
    int seq_code;
    int bad_line;
    int bad_gnt;
    int bad_done;
    int done_ok;
    logic seen_we;
    logic post_dc_gnt;
    logic [LINE_W-1:0] exp_line;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic push(input int kind, input logic [LINE_W-1:0] l);
        seq_code = (seq_code << 4) | kind;
        if (l != exp_line) bad_line++;
    endtask

    // Steps one sequence: records events, answers each bus request after
    // lat waiting cycles, and checks done timing at the acknowledge.
    task automatic run_trace(input int lat, input bit hold_dc);
        int  wcnt;
        bit  fin;
        wcnt = 0; fin = 0;
        seq_code = 0; bad_line = 0; bad_gnt = 0; bad_done = 0; done_ok = 0;
        seen_we = 1'b0;
        for (int c = 0; c < 60 && !fin; c++) begin
            @(negedge clk);
            ic_miss_req = 1'b0;
            if (!hold_dc) dc_miss_req = 1'b0;
            wb_ack = 1'b0; fill_ack = 1'b0; dacc_ack = 1'b0;
            #1;
            if (busy && (ic_miss_gnt || dc_miss_gnt)) bad_gnt++;
            if (ic_done || dc_done) bad_done++;
            if (dc_lkup_vld) push(EV_LKD, dc_lkup_line);
            if (dc_inv_vld)  push(EV_INVD, dc_inv_line);
            if (ic_lkup_vld) push(EV_LKI, ic_lkup_line);
            if (ic_inv_vld)  push(EV_INVI, ic_inv_line);
            if (wb_req || fill_req || dacc_req) begin
                if (wcnt == 0) begin
                    if (wb_req)   push(EV_WB, wb_line);
                    if (fill_req) push(EV_FILL, fill_line);
                    if (dacc_req) begin
                        push(EV_DACC, dacc_line);
                        seen_we = dacc_we;
                    end
                end
                wcnt++;
                if (wcnt > lat) begin
                    wcnt = 0;
                    if (wb_req) begin
                        wb_ack = 1'b1;
                        #1;
                        if (ic_done || dc_done) bad_done++;
                    end else if (fill_req) begin
                        fill_ack = 1'b1;
                        #1;
                        if (ic_done && !dc_done) done_ok = 1;
                        fin = 1;
                    end else begin
                        dacc_ack = 1'b1;
                        #1;
                        if (dc_done && !ic_done) done_ok = 1;
                        fin = 1;
                    end
                end
            end
        end
        @(negedge clk);
        wb_ack = 1'b0; fill_ack = 1'b0; dacc_ack = 1'b0;
        if (!hold_dc) dc_miss_req = 1'b0;
        #1;
        post_dc_gnt = dc_miss_gnt;
        chk(fin == 1, "R8", "sequence finished", fin, 1);
        chk(bad_line == 0, "R1", "event line mismatches", bad_line, 0);
        chk(bad_gnt == 0, "R8", "grants while busy", bad_gnt, 0);
        chk(done_ok == 1 && bad_done == 0, "R9", "done pulse at ack only", bad_done, 0);
        chk(!busy && !ic_done && !dc_done, "R9", "idle and done low after ack",
            {busy, ic_done, dc_done}, 0);
    endtask

    task automatic ic_scenario(input logic [LINE_W-1:0] line, input bit hit,
                               input logic [1:0] st, input int lat,
                               input int exp_seq, input string req);
        dc_lkup_hit = hit; dc_lkup_state = st; ic_lkup_hit = 1'b1;
        exp_line = line;
        @(negedge clk);
        ic_miss_req = 1'b1; ic_miss_line = line;
        #1;
        chk(ic_miss_gnt && !dc_miss_gnt && !busy, "R8", "instruction grant when idle",
            {ic_miss_gnt, dc_miss_gnt, busy}, 3'b100);
        run_trace(lat, 1'b0);
        chk(seq_code == exp_seq, req, "instruction miss event order", seq_code, exp_seq);
    endtask

    task automatic dc_scenario(input logic [LINE_W-1:0] line, input bit we,
                               input bit hit, input int lat,
                               input int exp_seq, input string req);
        ic_lkup_hit = hit; dc_lkup_hit = 1'b1; dc_lkup_state = 2'b11;
        exp_line = line;
        @(negedge clk);
        dc_miss_req = 1'b1; dc_miss_line = line; dc_miss_we = we;
        #1;
        chk(dc_miss_gnt && !ic_miss_gnt && !busy, "R8", "data grant when idle",
            {dc_miss_gnt, ic_miss_gnt, busy}, 3'b100);
        run_trace(lat, 1'b0);
        chk(seq_code == exp_seq, req, "data miss event order", seq_code, exp_seq);
        chk(seen_we == we, "R6", "data access write flag", seen_we, we);
    endtask

    task automatic both_scenario();
        logic [LINE_W-1:0] il;
        logic [LINE_W-1:0] dl;
        il = 27'h0123456; dl = 27'h7654321;
        dc_lkup_hit = 1'b1; dc_lkup_state = 2'b01; ic_lkup_hit = 1'b0;
        exp_line = il;
        @(negedge clk);
        ic_miss_req = 1'b1; ic_miss_line = il;
        dc_miss_req = 1'b1; dc_miss_line = dl; dc_miss_we = 1'b1;
        #1;
        chk(ic_miss_gnt && !dc_miss_gnt, "R8", "instruction wins tie",
            {ic_miss_gnt, dc_miss_gnt}, 2'b10);
        run_trace(1, 1'b1);
        chk(seq_code == 'h134, "R8", "first sequence is instruction", seq_code, 'h134);
        chk(post_dc_gnt == 1'b1, "R8", "stalled data miss granted after", post_dc_gnt, 1);
        exp_line = dl;
        run_trace(0, 1'b0);
        chk(seq_code == 'h57, "R8", "stalled data sequence", seq_code, 'h57);
        chk(seen_we == 1'b1, "R6", "stalled write flag", seen_we, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk({ic_miss_gnt, dc_miss_gnt, busy, dc_lkup_vld, dc_inv_vld, ic_lkup_vld,
             ic_inv_vld, wb_req, fill_req, dacc_req, ic_done, dc_done} == '0,
            "R10", "outputs low in reset",
            {ic_miss_gnt, dc_miss_gnt, busy, dc_lkup_vld, dc_inv_vld, ic_lkup_vld,
             ic_inv_vld, wb_req, fill_req, dacc_req, ic_done, dc_done}, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // R2 R3 R4: modified hit -> lookup, write-back, invalidate, fill
        ic_scenario(27'h55E6891, 1'b1, 2'b11, 2, 'h1234, "R2");
        // R3: shared and exclusive hits invalidate without write-back
        ic_scenario(27'h0000001, 1'b1, 2'b01, 1, 'h134, "R3");
        ic_scenario(27'h7FFFFFF, 1'b1, 2'b10, 0, 'h134, "R3");
        // R7 R4: lookup miss goes straight to fill
        ic_scenario(27'h1234567, 1'b0, 2'b00, 3, 'h14, "R7");
        // R7: state lines say modified but no hit -> no write-back
        ic_scenario(27'h2AAAAAA, 1'b0, 2'b11, 1, 'h14, "R7");
        // R5 R6: data read miss with instruction hit
        dc_scenario(27'h3C3C3C3, 1'b0, 1'b1, 1, 'h567, "R5");
        // R7 R6: data write miss with instruction miss
        dc_scenario(27'h4000000, 1'b1, 1'b0, 0, 'h57, "R7");
        // R5 R6: data write with instruction hit, long access
        dc_scenario(27'h0F0F0F0, 1'b1, 1'b1, 4, 'h567, "R6");
        // R8: simultaneous requests, stall and later grant
        both_scenario();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        fails++;
        checks++;
        $display("FAIL R8 watchdog actual=hung expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule